// File: doc/BRIEF.md
# Nine-Lane Odd-Even Transposition Sorter

This block sorts nine unsigned words into ascending order with a fixed network of compare-exchange cells, and brings out the middle word of the sorted result as a separate median output. The network has one column per lane. Each column holds four compare-exchange cells and one lane that passes straight through. The columns alternate between two pairings, so a value can move by at most one lane per column. With nine lanes, nine columns are needed before the order is guaranteed. A network cut short may leave the middle lane holding something other than the true median.

A typical use is a 3x3 neighbourhood median filter for pixel streams, which removes impulse noise. The nine window samples are presented together with a valid flag. With pipelining enabled, each column is followed by a register stage. The block then accepts one window per clock, and the sorted window and its median come out nine clocks later with the flag. With pipelining disabled, the whole network is one combinational path.

Top module: `oddeven_sort9`

## Requirements
- R1: A compare-exchange cell places the smaller of its two words on its lower-numbered lane and the larger on its higher-numbered lane; the cell holds one magnitude comparator.
- R2: Columns with an even index pair lanes (0,1),(2,3),(4,5),(6,7) and pass lane 8 through. Columns with an odd index pair lanes (1,2),(3,4),(5,6),(7,8) and pass lane 0 through. The network has N columns (nine), so even reverse-ordered input comes out fully sorted.
- R3: Word k of `in_data` and `out_data` occupies bits [8k+7:8k]. The output lanes are in non-decreasing order: lane 0 holds the minimum and lane 8 the maximum.
- R4: The nine output words form exactly the same multiset as the nine input words, duplicates included.
- R5: `median` carries output lane 4 (index (N-1)/2), the true median of the nine inputs.
- R6: With PIPE=1, a window presented with `in_valid` high appears on `out_data` with `out_valid` high exactly N (nine) clocks later. One new window is accepted on every clock.
- R7: With PIPE=0, the block is purely combinational and `out_valid`/`out_data` follow the inputs in the same cycle.
- R8: A synchronous active-high `rst` clears every in-flight valid flag, so no window accepted before the reset ever appears with `out_valid` high.
- R9: Input words presented while `in_valid` is low never produce an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a window to sort |
| in_data | input | N*W (72) | Nine unsorted words, word k at bits [W*k +: W] |
| out_valid | output | 1 | Marks `out_data` and `median` as a sorted result |
| out_data | output | N*W (72) | Nine words in ascending order, lane 0 smallest |
| median | output | W (8) | Middle lane of the sorted result |

## Verification
The network is driven with seeded random windows. Some are back to back and some have idle gaps carrying random data. Each result is compared lane by lane against a reference sort, and the arrival cycle is checked as well. Several directed windows are mixed in. Reverse-ordered input makes the extreme values travel the full width, which exposes a missing column or a wrong pairing that random data would rarely reveal. All-equal and heavily duplicated windows show whether ties are lost or duplicated, and already-sorted input shows whether the network disturbs order it should keep. A single swapped adjacent pair checks the direction of one cell. Separately, a reset issued with windows in flight must suppress all of them, and the combinational variant must match the reference in the same cycle.

// File: rtl/oddeven_sort9.sv
module oddeven_sort9 #(
  parameter int W    = 8,
  parameter int N    = 9,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data,
  output logic [W-1:0]   median
);

  localparam int MID = (N - 1) / 2;
  localparam int SW  = W + $clog2(N) + 1;

  logic [W-1:0] lane [0:N][0:N-1];
  logic [W-1:0] cx   [0:N-1][0:N-1];
  logic         swp  [0:N-1][0:N-1];
  logic         vld  [0:N];

  for (genvar i = 0; i < N; i++) begin : g_io
    assign lane[0][i]        = in_data[i*W +: W];
    assign out_data[i*W +: W] = lane[N][i];
  end
  assign vld[0]    = in_valid;
  assign out_valid = vld[N];
  assign median    = lane[N][MID];

  for (genvar s = 0; s < N; s++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_lane
      localparam bit IS_LO = ((i % 2) == (s % 2)) && (i + 1 < N);
      localparam bit IS_HI = (i > 0) && (((i - 1) % 2) == (s % 2));
      if (IS_LO) begin : g_lo
        assign swp[s][i] = lane[s][i] > lane[s][i+1];
        assign cx[s][i]  = swp[s][i] ? lane[s][i+1] : lane[s][i];
      end else if (IS_HI) begin : g_hi
        assign swp[s][i] = 1'b0;
        assign cx[s][i]  = swp[s][i-1] ? lane[s][i-1] : lane[s][i];
      end else begin : g_pass
        assign swp[s][i] = 1'b0;
        assign cx[s][i]  = lane[s][i];
      end
    end

    if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) vld[s+1] <= 1'b0;
        else     vld[s+1] <= vld[s];
        for (int i = 0; i < N; i++) lane[s+1][i] <= cx[s][i];
      end
    end else begin : g_wire
      assign vld[s+1] = vld[s];
      for (genvar i = 0; i < N; i++) begin : g_w
        assign lane[s+1][i] = cx[s][i];
      end
    end
  end

  logic [SW-1:0] sum_in [0:N-1];
  logic [SW-1:0] sum_cx [0:N-1];
  logic [W-1:0]  xor_in [0:N-1];
  logic [W-1:0]  xor_cx [0:N-1];
  logic          out_ordered;

  always_comb begin
    for (int s = 0; s < N; s++) begin
      sum_in[s] = '0;
      sum_cx[s] = '0;
      xor_in[s] = '0;
      xor_cx[s] = '0;
      for (int i = 0; i < N; i++) begin
        sum_in[s] = sum_in[s] + SW'(lane[s][i]);
        sum_cx[s] = sum_cx[s] + SW'(cx[s][i]);
        xor_in[s] = xor_in[s] ^ lane[s][i];
        xor_cx[s] = xor_cx[s] ^ cx[s][i];
      end
    end
    out_ordered = 1'b1;
    for (int i = 0; i + 1 < N; i++)
      if (lane[N][i] > lane[N][i+1]) out_ordered = 1'b0;
  end

  for (genvar s = 0; s < N; s++) begin : g_chk
    p_col_sum_r4: assert property (@(posedge clk) disable iff (rst)
      vld[s] |-> (sum_cx[s] == sum_in[s]));
    p_col_xor_r4: assert property (@(posedge clk) disable iff (rst)
      vld[s] |-> (xor_cx[s] == xor_in[s]));
  end

  p_out_order_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_ordered);

  p_median_bound_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (median >= out_data[W-1:0] && median <= out_data[N*W-1 -: W]));

endmodule

// File: tb/oddeven_sort9_tb.sv
`timescale 1ns/1ps
module oddeven_sort9_tb;
  localparam int W = 8;
  localparam int N = 9;
  localparam int MID = (N - 1) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic out_valid, c_valid;
  logic [N*W-1:0] out_data, c_data;
  logic [W-1:0] median, c_median;

  always #2.5 clk = ~clk;

  oddeven_sort9 #(.W(W), .N(N), .PIPE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .median(median));

  oddeven_sort9 #(.W(W), .N(N), .PIPE(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(c_valid), .out_data(c_data), .median(c_median));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [N*W-1:0] exp_q[$];
  int cyc_q[$];
  string tag_q[$];

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 1; i < N; i++) begin
      t = a[i];
      for (int j = i; j > 0; j--) begin
        if (a[j-1] > t) begin a[j] = a[j-1]; a[j-1] = t; end
      end
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic compare(input string tag, input logic [N*W-1:0] got,
                         input logic [W-1:0] got_med, input logic [N*W-1:0] exp);
    bit bad = 0;
    n_chk++;
    for (int i = 0; i < N; i++) begin
      if (got[i*W +: W] !== exp[i*W +: W]) begin
        if (!bad) $display("FAIL %s R3 R4 lane %0d: got %0d expected %0d", tag, i,
                           got[i*W +: W], exp[i*W +: W]);
        bad = 1;
      end
    end
    if (got_med !== exp[MID*W +: W]) begin
      $display("FAIL %s R5 median: got %0d expected %0d", tag, got_med, exp[MID*W +: W]);
      bad = 1;
    end
    if (bad) n_bad++;
  endtask

  // pipelined scoreboard, called at each negedge before new drive
  task automatic check_pipe();
    if (out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 spurious out_valid: got 1 expected 0");
      end else begin
        logic [N*W-1:0] e = exp_q.pop_front();
        int c0 = cyc_q.pop_front();
        string tg = tag_q.pop_front();
        n_chk++;
        if (cyc - c0 != N) begin
          n_bad++;
          $display("FAIL R6 latency: got %0d expected %0d", cyc - c0, N);
        end
        compare({tg, " pipe"}, out_data, median, e);
      end
    end else if (exp_q.size() != 0 && cyc - cyc_q[0] >= N) begin
      n_chk++; n_bad++;
      $display("FAIL R6 missing result: got out_valid 0 expected 1");
      void'(exp_q.pop_front()); void'(cyc_q.pop_front()); void'(tag_q.pop_front());
    end
  endtask

  task automatic step(input bit v, input logic [N*W-1:0] d, input string tag);
    @(negedge clk);
    cyc++;
    check_pipe();
    in_valid = v;
    in_data = d;
    if (v) begin
      exp_q.push_back(ref_sort(d));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    #1;
    n_chk++;
    if (c_valid !== v) begin
      n_bad++;
      $display("FAIL R7 comb valid: got %0b expected %0b", c_valid, v);
    end
    if (v) compare({tag, " comb R7"}, c_data, c_median, ref_sort(d));
  endtask

  function automatic logic [N*W-1:0] rnd_vec(input bit dup);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*W +: W] = dup ? W'($urandom_range(0, 3) * 85) : W'($urandom);
    return r;
  endfunction

  initial begin
    logic [N*W-1:0] v;
    void'($urandom(32'h5eed_0b1e));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R8 reset state: got %0b expected 0", out_valid);
    end

    // R1: one adjacent pair out of order
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(10 * i);
    v[0 +: W] = 8'd10; v[W +: W] = 8'd0;
    step(1, v, "R1 single swap");
    // R2: reverse sorted, extremes travel full width
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(250 - 20 * i);
    step(1, v, "R2 reverse");
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(255 - i);
    step(1, v, "R2 reverse tight");
    // R3: already sorted
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(3 + 7 * i);
    step(1, v, "R3 sorted");
    // R4: all equal, and heavy duplicates
    step(1, {N{8'hA5}}, "R4 all equal");
    step(1, {8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00}, "R4 dup");
    step(1, {8'hFF, {(N-1){8'h00}}}, "R5 max top");
    step(1, {{(N-1){8'hFF}}, 8'h00}, "R5 min bottom");
    // R9: idle cycles with random data
    repeat (12) step(0, rnd_vec(0), "R9 idle");

    // random, back to back and with gaps
    for (int k = 0; k < 300; k++) begin
      bit dup = ($urandom_range(0, 3) == 0);
      step(($urandom_range(0, 4) != 0), rnd_vec(dup), dup ? "R4 rand dup" : "R3 rand");
    end
    repeat (N + 2) step(0, rnd_vec(0), "R9 drain");

    // R8: reset with windows in flight
    for (int k = 0; k < 4; k++) step(1, rnd_vec(0), "R8 pre reset");
    @(negedge clk);
    cyc++;
    rst = 1'b1; in_valid = 1'b0;
    exp_q.delete(); cyc_q.delete(); tag_q.delete();
    @(negedge clk);
    cyc++;
    rst = 1'b0;
    for (int k = 0; k < N + 3; k++) begin
      @(negedge clk);
      cyc++;
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_bad++; $display("FAIL R8 flushed window appeared: got 1 expected 0");
      end
    end
    for (int k = 0; k < 20; k++) step(1, rnd_vec(0), "R6 after reset");
    repeat (N + 2) step(0, '0, "R9 final drain");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule